// File: doc/BRIEF.md
# Dual-Channel PWM Generator

This peripheral produces two independent pulse-width modulated outputs under control of a small register file. The register file is reached through a 32-bit port addressed by word index. Each channel has its own period register (the number of pulse-clock steps in one period) and its own duty register (how many of those steps are high). One shared control word sets, for each channel, whether it runs, whether it is inverted, the level it rests at while idle, and which waveform style it uses.

In the contiguous style, each period begins with one unbroken high pulse. In the spread style, the same number of high steps is scattered as evenly as possible across the period, which raises the ripple frequency seen by a filter on the pin. A clock-enable input paces both channels, so the pulse step rate is independent of the bus clock.

Several control bits are stored and read back but do not change the outputs: serializer select, repeat-last, FIFO use and FIFO clear.

Top module: `dual_pwm`

## Requirements
- R1: Word index 0 holds the control word and word index 1 holds status. Channel 1 period is at index 4 and its duty at index 5. Channel 2 period is at index 8 and its duty at index 9. Period and duty registers read back what was written, zero-extended from CNT_W bits. Read data appears one clock after the address is presented. After reset every register reads 0 and both outputs are 0.
- R2: The control word keeps only bits 15:0, and bits 6 and 14 always read 0. All other bits of 15:0 read back as written. The status word always reads 0 and ignores writes.
- R3: Channel 1 uses control bits 0 (run), 3 (idle level), 4 (invert) and 7 (contiguous style). Channel 2 uses the same bits plus 8, that is bits 8, 11, 12 and 15. A channel whose run bit is 0 drives its idle level, and inversion does not apply to that level.
- R4: With the style bit at 1, step k of a period (k from 0 to P-1) is high exactly when k < D, where P is the period and D is the duty.
- R5: With the style bit at 0, step k is high exactly when floor((k+1)·D/P) > floor(k·D/P). Each period therefore holds exactly D high steps, spread evenly.
- R6: A duty of P or more makes every step of the period high in both styles. A duty of 0 makes every step low.
- R7: A period of 0 on a running channel holds its output at the idle level.
- R8: The invert bit complements the output of a running channel.
- R9: New period and duty values are used only from the next period boundary. A period in progress always completes with the values it started with.
- R10: The step position and the output change only on clocks where the enable input is high. With the enable input low, a running channel's output holds.
- R11: Clearing a channel's run bit returns it to step 0, so running it again starts a fresh period.
- R12: The serializer, repeat-last, FIFO-use and FIFO-clear bits (1, 2, 5, 6 and 9, 10, 13) have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Pulse-step enable; both channels advance only when high |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Word index of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the word presented on the previous clock |
| pwm_out | output | 2 | Channel outputs, bit 0 is channel 1 |

## Verification
Some properties are checked on every cycle. The step counter and the spread-style accumulator stay below the latched period. The output holds while the enable input is low. An idle channel shows its idle level one clock after it is stopped. The reserved control bits read back as zero. The actual waveform shapes can only be shown by the bench scenarios, which compare each output step against a closed-form reference. These include the exact placement of spread-style pulses and the deferral of period and duty changes to the next boundary. They also cover restart after a stop, the saturating and zero duty cases, and the zero period case.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int NCH      = 2;
  localparam int LANE_W   = 8;
  localparam int CTRL_W   = NCH * LANE_W;
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_STEP = 4;

  // bit positions inside one channel's control lane
  localparam int L_RUN  = 0;
  localparam int L_IDLE = 3;
  localparam int L_INV  = 4;
  localparam int L_MS   = 7;

  // lane bit 6 (fifo clear) of lane 0 and bit 14 (unused) always read 0
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'hBFBF;

  typedef struct packed {
    logic ms;
    logic inv;
    logic idle;
    logic run;
  } lane_cfg_t;

  function automatic lane_cfg_t lane_cfg(input logic [LANE_W-1:0] lane);
    lane_cfg_t c;
    c.ms   = lane[L_MS];
    c.inv  = lane[L_INV];
    c.idle = lane[L_IDLE];
    c.run  = lane[L_RUN];
    return c;
  endfunction

  function automatic int period_idx(input int ch);
    return IDX_STEP * (ch + 1);
  endfunction

  function automatic int duty_idx(input int ch);
    return IDX_STEP * (ch + 1) + 1;
  endfunction
endpackage

// File: rtl/dual_pwm_lane.sv
module dual_pwm_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             ms,
  input  logic             inv,
  input  logic             idle,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic             wave
);
  logic [CNT_W-1:0] pos, acc, per_act, duty_act;
  logic [CNT_W-1:0] per_eff, duty_eff, duty_clip, acc_base;
  logic [CNT_W:0]   sum;
  logic             at_edge, hit, raw;

  assign at_edge   = (pos == '0);
  assign per_eff   = at_edge ? period_in : per_act;
  assign duty_eff  = at_edge ? duty_in   : duty_act;
  assign duty_clip = (duty_eff > per_eff) ? per_eff : duty_eff;
  assign acc_base  = at_edge ? '0 : acc;
  assign sum       = {1'b0, acc_base} + {1'b0, duty_clip};
  assign hit       = (sum >= {1'b0, per_eff});
  assign raw       = ms ? (pos < duty_clip) : hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      acc      <= '0;
      per_act  <= '0;
      duty_act <= '0;
      wave     <= 1'b0;
    end else if (!run) begin
      pos  <= '0;
      acc  <= '0;
      wave <= idle;
    end else if (tick) begin
      per_act  <= per_eff;
      duty_act <= duty_eff;
      if (per_eff == '0) begin
        pos  <= '0;
        acc  <= '0;
        wave <= idle;
      end else begin
        pos  <= (pos == per_eff - 1'b1) ? '0 : pos + 1'b1;
        acc  <= hit ? CNT_W'(sum - {1'b0, per_eff}) : CNT_W'(sum);
        wave <= raw ^ inv;
      end
    end
  end

  AST_POS_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (per_act != '0) |-> (pos < per_act)); // R9
  AST_ACC_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (per_act != '0) |-> (acc < per_act)); // R5
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(wave)); // R10
  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (wave == $past(idle))); // R3
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import dual_pwm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  per_q  [NCH];
  logic [CNT_W-1:0]  duty_q [NCH];
  logic [31:0]       rd_mux;
  wire               unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        per_q[c]  <= '0;
        duty_q[c] <= '0;
      end
    end else if (wr_en) begin
      if (addr == ADDR_W'(IDX_CTRL)) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
      for (int c = 0; c < NCH; c++) begin
        if (addr == ADDR_W'(period_idx(c))) per_q[c]  <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(duty_idx(c)))   duty_q[c] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(IDX_CTRL)) rd_mux = 32'(ctrl_q);
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(period_idx(c))) rd_mux = 32'(per_q[c]);
      if (addr == ADDR_W'(duty_idx(c)))   rd_mux = 32'(duty_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    lane_cfg_t cfg;
    assign cfg = lane_cfg(ctrl_q[g*LANE_W +: LANE_W]);
    dual_pwm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .run       (cfg.run),
      .ms        (cfg.ms),
      .inv       (cfg.inv),
      .idle      (cfg.idle),
      .period_in (per_q[g]),
      .duty_in   (duty_q[g]),
      .wave      (pwm_out[g])
    );
  end

  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(IDX_CTRL)) |->
      (rdata[6] == 1'b0 && rdata[14] == 1'b0 && rdata[31:16] == '0)); // R2
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(IDX_STAT)) |-> (rdata == '0)); // R2
endmodule

// File: tb/dual_pwm_test.sv
module dual_pwm_test;
  localparam int AW = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] pwm_out;

  always #10 clk = ~clk;

  dual_pwm #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] m_ctrl = '0;
  longint m_per[2] = '{0, 0};
  longint m_duty[2] = '{0, 0};
  longint m_pos[2] = '{0, 0};
  longint m_pa[2] = '{0, 0};
  longint m_da[2] = '{0, 0};

  typedef struct { logic [1:0] e; string tag; } item_t;
  item_t sb[$];
  logic tick_d = 1'b0;

  always @(posedge clk) tick_d <= tick;

  // monitor
  always @(negedge clk) begin
    if (tick_d) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL %s scoreboard empty, actual %b expected none", "R10", pwm_out);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (pwm_out !== it.e) begin
          errors++;
          $display("FAIL %s pwm_out actual %b expected %b", it.tag, pwm_out, it.e);
        end
      end
    end
  end

  task automatic model_step(input int c, output logic b);
    logic run, idle, inv, ms;
    longint d, p, k;
    run  = m_ctrl[8*c + 0];
    idle = m_ctrl[8*c + 3];
    inv  = m_ctrl[8*c + 4];
    ms   = m_ctrl[8*c + 7];
    if (!run) begin
      m_pos[c] = 0;
      b = idle;
      return;
    end
    if (m_pos[c] == 0) begin
      m_pa[c] = m_per[c];
      m_da[c] = m_duty[c];
    end
    if (m_pa[c] == 0) begin
      b = idle;
      return;
    end
    p = m_pa[c];
    d = (m_da[c] > p) ? p : m_da[c];
    k = m_pos[c];
    if (ms) b = (k < d);
    else    b = (((k + 1) * d) / p) > ((k * d) / p);
    b = b ^ inv;
    m_pos[c] = (k == p - 1) ? 0 : k + 1;
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic b0, b1;
      @(negedge clk);
      model_step(0, b0);
      model_step(1, b1);
      it.e = {b1, b0};
      it.tag = tag;
      sb.push_back(it);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr = AW'(a);
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: begin
        m_ctrl = d[15:0] & 16'hBFBF;
        for (int c = 0; c < 2; c++) if (!m_ctrl[8*c]) m_pos[c] = 0;
      end
      4: m_per[0]  = longint'(d[CW-1:0]);
      5: m_duty[0] = longint'(d[CW-1:0]);
      8: m_per[1]  = longint'(d[CW-1:0]);
      9: m_duty[1] = longint'(d[CW-1:0]);
      default: ;
    endcase
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read idx %0d actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic hold_check(input int n);
    logic [1:0] last;
    last = pwm_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (pwm_out !== last) begin
        errors++;
        $display("FAIL R10 output moved without tick actual %b expected %b", pwm_out, last);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (pwm_out !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b expected 00", pwm_out);
    end
    rd_check(0, 32'h0, "R1");
    rd_check(4, 32'h0, "R1");
    rd_check(9, 32'h0, "R1");

    // R1 map and readback
    wr(4, 32'd10);
    wr(5, 32'd3);
    wr(8, 32'd7);
    wr(9, 32'd5);
    rd_check(4, 32'd10, "R1");
    rd_check(5, 32'd3, "R1");
    rd_check(8, 32'd7, "R1");
    rd_check(9, 32'd5, "R1");

    // R2: control masking and status
    wr(0, 32'hFFFF_FFFF);
    rd_check(0, 32'h0000_BFBF, "R2");
    wr(1, 32'h1234_5678);
    rd_check(1, 32'h0, "R2");
    wr(0, 32'h0);

    // R3 R4: ch1 contiguous, ch2 stopped with idle high
    wr(0, 32'h0000_0881);
    rd_check(0, 32'h0000_0881, "R2");
    run_ticks(22, "R3 R4");

    // R5: spread style on both channels
    wr(0, 32'h0);
    wr(0, 32'h0000_0101);
    run_ticks(30, "R5");

    // R6: saturating and zero duty, both styles
    wr(0, 32'h0);
    wr(5, 32'd15);
    wr(9, 32'd0);
    wr(0, 32'h0000_0101);
    run_ticks(14, "R6");
    wr(0, 32'h0);
    wr(0, 32'h0000_8181);
    run_ticks(14, "R6");

    // R8: inversion in both styles
    wr(0, 32'h0);
    wr(5, 32'd3);
    wr(9, 32'd2);
    wr(0, 32'h0000_1191);
    run_ticks(16, "R8");

    // R7: zero period holds idle level
    wr(0, 32'h0);
    wr(4, 32'd0);
    wr(0, 32'h0000_0009);
    run_ticks(5, "R7");
    wr(0, 32'h0000_0001);
    run_ticks(3, "R7");

    // R9: mid-period update deferred to boundary
    wr(0, 32'h0);
    wr(4, 32'd8);
    wr(5, 32'd2);
    wr(0, 32'h0000_0081);
    run_ticks(3, "R9");
    // R10: hold with tick low, mid-period
    hold_check(6);
    wr(5, 32'd6);
    wr(4, 32'd12);
    run_ticks(22, "R9");

    // R11: stop then restart from step 0
    run_ticks(5, "R11");
    wr(0, 32'h0000_0080);
    wr(0, 32'h0000_0081);
    run_ticks(12, "R11");

    // R12: inert bits have no effect
    wr(0, 32'h0);
    wr(0, 32'h0000_A7E7);
    rd_check(0, 32'h0000_A7A7, "R12");
    run_ticks(16, "R12");
    wr(0, 32'h0000_2705);
    run_ticks(14, "R12");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 unconsumed expectations actual %0d expected 0", sb.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule